// File: doc/BRIEF.md
# BCD calendar timekeeping core

This core holds the time of day and the calendar date as eight packed-BCD byte fields: hundredths, seconds, minutes, hours, day of week, date, month and a two-digit year. A single-cycle `tick` pulse, expected once per hundredth of a second, advances the count. The carry ripples through every field in the same cycle. Month lengths and leap years are applied when the date rolls over.

An outside controller writes all eight fields at once through a 64-bit parallel load. The whole state is always visible as a 64-bit image. Byte k of the image is field k.

The hours field supports a 12-hour presentation with an AM/PM flag and a 24-hour presentation. The day-of-week field also carries a halt bit that freezes counting, and a reset-enable bit that the core stores for its neighbour. The core has no sequencing state machine. Its only state is the register image, and the next image is a combinational function of the current image and the inputs.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the image is 64'h0001_0131_0000_0000. Year is 00, month 01, date 01 and hours 00 in 24-hour mode. Byte 4 is 8'h31, meaning halt bit 5 is set, reset-enable bit 4 is set and day of week is 1. All other fields are 00.
- R2: Byte 0 holds hundredths in packed BCD, tenths in bits 7:4 and hundredths in bits 3:0. Each counted tick adds one to byte 0. From 99 it goes to 00 and carries into seconds.
- R3: Seconds (byte 1) and minutes (byte 2) count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R4: When byte 3 bit 7 is 0, the hours field is in 24-hour mode and bits 5:0 count 00 to 23. The step from 23 goes to 00 and advances the date.
- R5: When byte 3 bit 7 is 1, the hours field is in 12-hour mode. Bits 4:0 count 01 to 12 and bit 5 is PM. The step from 11 goes to 12 and toggles bit 5. The step from 12 goes to 01 and leaves bit 5 unchanged. The date advances only on the step from 11 PM to 12 AM.
- R6: Day of week is byte 4 bits 2:0. It goes from 7 to 1 and otherwise adds one, but only when the date advances. Bits 5 and 4 of byte 4 are left unchanged by counting.
- R7: Date is byte 5. April, June, September and November end at 30, and all other months except February end at 31. The step past the last day sets the date to 01 and advances the month (byte 6).
- R8: February ends at 29 when the two-digit year is divisible by 4, including 00, and at 28 otherwise.
- R9: The step past month 12 sets the month to 01 and advances the year (byte 7). The year goes from 99 to 00.
- R10: While byte 4 bit 5 is 1, ticks change nothing.
- R11: With `load` high, the masked `load_img` appears on `time_img` after the next clock edge. A tick in the same cycle is ignored.
- R12: A load clears the bits that always read 0, using the mask 64'hFF1F_3F37_BF7F_7FFF.
- R13: With `tick` and `load` both low, the image holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse per hundredth of a second |
| load | input | 1 | Parallel write of all eight fields |
| load_img | input | 64 | Image to be written, byte k is field k |
| time_img | output | 64 | Current field image, byte k is field k |

## Verification
Every effect of `tick` or `load` appears on `time_img` one clock edge after the cycle in which it was presented. The effect includes a full carry from hundredths through the year. The bench drives inputs on the falling edge and samples on the next falling edge, half a period after the register update. The expected image is advanced by a bench model in the same step. The directed corner cases are end of month, leap February, 11 PM in 12-hour mode, the end of the year and a halted clock. Around them, seeded random loads are biased toward rollover values, and random tick gaps are mixed in.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 8;
    localparam int IMG_W      = FIELD_W * NUM_FIELDS;
    localparam int DOW_W      = 3;

    localparam int F_CENTI = 0;
    localparam int F_SEC   = 1;
    localparam int F_MIN   = 2;
    localparam int F_HOUR  = 3;
    localparam int F_DOW   = 4;
    localparam int F_DATE  = 5;
    localparam int F_MONTH = 6;
    localparam int F_YEAR  = 7;

    localparam int HALT_BIT    = 5;
    localparam int MODE12_BIT  = 7;
    localparam int TIME_FIELDS = 3;

    localparam logic [TIME_FIELDS-1:0][FIELD_W-1:0] TIME_LIMIT = {8'h59, 8'h59, 8'h99};
    localparam logic [IMG_W-1:0] LOAD_MASK = 64'hFF1F_3F37_BF7F_7FFF;
    localparam logic [IMG_W-1:0] RESET_IMG = 64'h0001_0131_0000_0000;
endpackage

// File: rtl/cal_bcd_step.sv
module cal_bcd_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] limit,
    input  logic [W-1:0] floor_val,
    output logic [W-1:0] nxt,
    output logic         at_limit
);
    localparam int DW = W / 2;

    always_comb begin
        at_limit = (val == limit);
        if (at_limit)
            nxt = floor_val;
        else if (val[DW-1:0] == DW'(9))
            nxt = {val[W-1:DW] + DW'(1), DW'(0)};
        else
            nxt = {val[W-1:DW], val[DW-1:0] + DW'(1)};
    end
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step (
    input  logic       mode12,
    input  logic       bit5,
    input  logic [4:0] low,
    output logic [7:0] nxt,
    output logic       day_carry
);
    always_comb begin
        day_carry = 1'b0;
        if (mode12) begin
            if (low == 5'h11) begin
                nxt       = {1'b1, 1'b0, ~bit5, 5'h12};
                day_carry = bit5;
            end else if (low == 5'h12) begin
                nxt = {1'b1, 1'b0, bit5, 5'h01};
            end else if (low[3:0] == 4'd9) begin
                nxt = {1'b1, 1'b0, bit5, 1'b1, 4'd0};
            end else begin
                nxt = {1'b1, 1'b0, bit5, low[4], low[3:0] + 4'd1};
            end
        end else begin
            if ({bit5, low} == 6'h23) begin
                nxt       = 8'h00;
                day_carry = 1'b1;
            end else if (low[3:0] == 4'd9) begin
                nxt = {2'b00, {bit5, low[4]} + 2'd1, 4'd0};
            end else begin
                nxt = {2'b00, bit5, low[4], low[3:0] + 4'd1};
            end
        end
    end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len #(
    parameter int W = 8
) (
    input  logic [W-1:0] month,
    input  logic [W-1:0] year,
    output logic [W-1:0] last_day
);
    localparam int DW = W / 2;

    logic [1:0] year_mod4;
    logic       leap;

    // BCD tens weigh 10 = 2 (mod 4), so year mod 4 = 2*tens + units (mod 4)
    assign year_mod4 = 2'({year[W-1:DW], 1'b0} + {1'b0, year[DW-1:0]});
    assign leap      = (year_mod4 == 2'd0);

    always_comb begin
        if (month == W'(8'h02))
            last_day = leap ? W'(8'h29) : W'(8'h28);
        else if (month == W'(8'h04) || month == W'(8'h06) ||
                 month == W'(8'h09) || month == W'(8'h11))
            last_day = W'(8'h30);
        else
            last_day = W'(8'h31);
    end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [IMG_W-1:0] load_img,
    output logic [IMG_W-1:0] time_img
);
    logic [NUM_FIELDS-1:0][FIELD_W-1:0]  fld_q, fld_d;
    logic [TIME_FIELDS-1:0][FIELD_W-1:0] time_nxt;
    logic [TIME_FIELDS-1:0]              time_wrap;
    logic [FIELD_W-1:0] hour_nxt, date_nxt, month_nxt, year_nxt, month_last;
    logic hour_carry, date_wrap, month_wrap, year_wrap;
    logic en_centi, en_sec, en_min, en_hour, en_day, en_month, en_year;

    // hundredths, seconds, minutes share one stepper shape
    for (genvar g = 0; g < TIME_FIELDS; g++) begin : g_time
        cal_bcd_step #(.W(FIELD_W)) u_step (
            .val      (fld_q[g]),
            .limit    (TIME_LIMIT[g]),
            .floor_val('0),
            .nxt      (time_nxt[g]),
            .at_limit (time_wrap[g])
        );
    end

    cal_hour_step u_hour (
        .mode12   (fld_q[F_HOUR][MODE12_BIT]),
        .bit5     (fld_q[F_HOUR][5]),
        .low      (fld_q[F_HOUR][4:0]),
        .nxt      (hour_nxt),
        .day_carry(hour_carry)
    );

    cal_month_len #(.W(FIELD_W)) u_mlen (
        .month   (fld_q[F_MONTH]),
        .year    (fld_q[F_YEAR]),
        .last_day(month_last)
    );

    cal_bcd_step #(.W(FIELD_W)) u_date (
        .val(fld_q[F_DATE]), .limit(month_last), .floor_val(FIELD_W'(1)),
        .nxt(date_nxt), .at_limit(date_wrap)
    );

    cal_bcd_step #(.W(FIELD_W)) u_month (
        .val(fld_q[F_MONTH]), .limit(FIELD_W'(8'h12)), .floor_val(FIELD_W'(1)),
        .nxt(month_nxt), .at_limit(month_wrap)
    );

    cal_bcd_step #(.W(FIELD_W)) u_year (
        .val(fld_q[F_YEAR]), .limit(FIELD_W'(8'h99)), .floor_val('0),
        .nxt(year_nxt), .at_limit(year_wrap)
    );

    // single-cycle carry ripple
    assign en_centi = tick & ~fld_q[F_DOW][HALT_BIT];
    assign en_sec   = en_centi & time_wrap[0];
    assign en_min   = en_sec   & time_wrap[1];
    assign en_hour  = en_min   & time_wrap[2];
    assign en_day   = en_hour  & hour_carry;
    assign en_month = en_day   & date_wrap;
    assign en_year  = en_month & month_wrap;

    always_comb begin
        fld_d = fld_q;
        if (load) begin
            fld_d = load_img & LOAD_MASK;
        end else begin
            if (en_centi) fld_d[F_CENTI] = time_nxt[0];
            if (en_sec)   fld_d[F_SEC]   = time_nxt[1];
            if (en_min)   fld_d[F_MIN]   = time_nxt[2];
            if (en_hour)  fld_d[F_HOUR]  = hour_nxt;
            if (en_day) begin
                fld_d[F_DOW][DOW_W-1:0] = (fld_q[F_DOW][DOW_W-1:0] == DOW_W'(7)) ?
                                          DOW_W'(1) : fld_q[F_DOW][DOW_W-1:0] + DOW_W'(1);
                fld_d[F_DATE] = date_nxt;
            end
            if (en_month) fld_d[F_MONTH] = month_nxt;
            if (en_year)  fld_d[F_YEAR]  = year_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld_q <= RESET_IMG;
        else        fld_q <= fld_d;
    end

    assign time_img = fld_q;

    // R11: load wins and lands on the next edge
    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> time_img == ($past(load_img) & LOAD_MASK));
    // R12: bits that always read 0 stay 0
    p_zero_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (time_img & ~LOAD_MASK) == '0);
    // R10: halted image does not move
    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && fld_q[F_DOW][HALT_BIT]) |=> $stable(time_img));
    // R13: no tick, no change
    p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(time_img));
    // R3: seconds wrap to zero
    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en_sec && fld_q[F_SEC] == 8'h59) |=> fld_q[F_SEC] == 8'h00);
    // R6: day of week wraps 7 to 1
    p_dow_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en_day && fld_q[F_DOW][DOW_W-1:0] == 3'd7) |=> fld_q[F_DOW][DOW_W-1:0] == 3'd1);
    // R5: 11 to 12 toggles the PM flag
    p_pm_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en_hour && fld_q[F_HOUR][MODE12_BIT] && fld_q[F_HOUR][4:0] == 5'h11)
        |=> fld_q[F_HOUR][5] != $past(fld_q[F_HOUR][5]));
endmodule

// File: tb/bcd_calendar_core_test.sv
module bcd_calendar_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load = 1'b0;
    logic [63:0] load_img = '0;
    logic [63:0] time_img;
    logic [63:0] model;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [63:0] MASK = 64'hFF1F_3F37_BF7F_7FFF;

    bcd_calendar_core uut (.clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
                           .load_img(load_img), .time_img(time_img));

    always #4 clk = ~clk;

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int mlen(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    // expected image one hundredth later
    function automatic logic [63:0] step(input logic [63:0] s);
        logic [7:0] f [8];
        logic [7:0] t;
        bit c, pm;
        int v, d, m, y;
        for (int k = 0; k < 8; k++) f[k] = s[k*8 +: 8];
        v = b2i(f[0]); c = (v == 99); f[0] = c ? 8'h00 : i2b(v + 1);
        if (c) begin v = b2i(f[1]); c = (v == 59); f[1] = c ? 8'h00 : i2b(v + 1); end
        if (c) begin v = b2i(f[2]); c = (v == 59); f[2] = c ? 8'h00 : i2b(v + 1); end
        if (c) begin
            if (f[3][7]) begin
                v = b2i({3'b0, f[3][4:0]}); pm = f[3][5]; c = 1'b0;
                if (v == 11) begin v = 12; c = pm; pm = !pm; end
                else if (v == 12) v = 1;
                else v = v + 1;
                t = i2b(v); f[3] = {2'b10, pm, t[4:0]};
            end else begin
                v = b2i({2'b0, f[3][5:0]}); c = (v == 23);
                t = i2b(c ? 0 : v + 1); f[3] = {2'b00, t[5:0]};
            end
        end
        if (c) begin
            f[4][2:0] = (f[4][2:0] == 3'd7) ? 3'd1 : f[4][2:0] + 3'd1;
            d = b2i(f[5]); m = b2i(f[6]); y = b2i(f[7]);
            if (d == mlen(m, y)) begin
                d = 1;
                if (m == 12) begin m = 1; y = (y == 99) ? 0 : y + 1; end
                else m = m + 1;
            end else d = d + 1;
            f[5] = i2b(d); f[6] = i2b(m); f[7] = i2b(y);
        end
        for (int k = 0; k < 8; k++) s[k*8 +: 8] = f[k];
        return s;
    endfunction

    function automatic logic [63:0] rand_img();
        logic [7:0] f [8];
        logic [7:0] t;
        logic [63:0] r;
        int m, y, ml;
        f[0] = i2b(($urandom % 2) ? 99 : int'($urandom % 100));
        f[1] = i2b(($urandom % 2) ? 59 : int'($urandom % 60));
        f[2] = i2b(($urandom % 2) ? 59 : int'($urandom % 60));
        if ($urandom % 2) begin
            t = i2b(($urandom % 2) ? 11 + int'($urandom % 2) : 1 + int'($urandom % 12));
            f[3] = {2'b10, 1'($urandom % 2), t[4:0]};
        end else begin
            t = i2b(($urandom % 2) ? 23 : int'($urandom % 24));
            f[3] = {2'b00, t[5:0]};
        end
        f[4] = {2'b00, 1'(($urandom % 8) == 0), 1'($urandom % 2), 1'b0, 3'(1 + $urandom % 7)};
        y = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
        m = ($urandom % 3 == 0) ? 2 : 1 + int'($urandom % 12);
        ml = mlen(m, y);
        f[5] = i2b(($urandom % 2) ? ml : 1 + int'($urandom % ml));
        f[6] = i2b(m); f[7] = i2b(y);
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = f[k];
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive at falling edge, result due after the next rising edge
    task automatic cyc(input logic ld, input logic [63:0] img, input logic tk, input string tag);
        load = ld; load_img = img; tick = tk;
        if (ld) model = img & MASK;
        else if (tk && !model[37]) model = step(model);
        @(negedge clk);
        check(tag, time_img, model);
    endtask

    task automatic directed(input string tag, input logic [63:0] start, input logic [63:0] exp);
        cyc(1'b1, start, 1'b0, "R11 load");
        cyc(1'b0, '0, 1'b1, tag);
        check(tag, time_img, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model = 64'h0001_0131_0000_0000;
        repeat (2) @(negedge clk);
        check("R1 reset", time_img, 64'h0001_0131_0000_0000);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(1'b0, '0, 1'b1, "R10 halted after reset");
        check("R1 halted reset", time_img, 64'h0001_0131_0000_0000);

        directed("R5 11PM to 12AM, R8 leap Feb 29, R6 dow 7->1",
                 64'h0002_2817_B159_5999, 64'h0002_2911_9200_0000);
        directed("R5 11AM to 12PM", 64'h0002_2817_9159_5999, 64'h0002_2817_B200_0000);
        directed("R5 12PM to 01PM", 64'h0002_2817_B259_5999, 64'h0002_2817_A100_0000);
        directed("R4 R8 non-leap Feb 28", 64'h2302_2803_2359_5999, 64'h2303_0104_0000_0000);
        directed("R7 Apr 30", 64'h2304_3005_2359_5999, 64'h2305_0106_0000_0000);
        directed("R7 May 30", 64'h2305_3005_2359_5999, 64'h2305_3106_0000_0000);
        directed("R9 year 99 to 00", 64'h9912_3107_2359_5999, 64'h0001_0101_0000_0000);
        directed("R2 R3 minute carry", 64'h2301_0101_0559_5999, 64'h2301_0101_0600_0000);
        directed("R10 halt", 64'h2301_0121_2359_5999, 64'h2301_0121_2359_5999);

        cyc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R12 mask");
        check("R12 mask", time_img, 64'hFF1F_3F37_BF7F_7FFF);
        cyc(1'b1, 64'h2301_0101_0559_5999, 1'b1, "R11 load over tick");
        check("R11 load over tick", time_img, 64'h2301_0101_0559_5999);
        cyc(1'b0, '0, 1'b0, "R13 idle");
        check("R13 idle", time_img, 64'h2301_0101_0559_5999);

        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 100 < 5) cyc(1'b1, rand_img(), 1'($urandom % 2), "R11 R12 random load");
            else if ($urandom % 10 < 9) cyc(1'b0, '0, 1'b1, "R2 R3 R4 R7 random tick");
            else cyc(1'b0, '0, 1'b0, "R13 random idle");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule